// File: doc/BRIEF.md
# SPI Ferroelectric Memory Slave

This block is a synthesizable serial memory that answers an SPI master like a small ferroelectric RAM. It holds 2 KiB of byte storage. A command opcode is the first byte of every chip-select frame, and the block accepts only that one opcode in the frame. Writes are gated by a write-enable latch. A write frame or a read frame carries a 16-bit start address. After the address, data bytes keep flowing to or from consecutive locations for as long as the master holds chip-select low.

Each burst needs only one enable frame, and its length is set only by chip-select, so a host can store a long block with little overhead. The SPI pins are sampled with the system clock through synchronisers. The master's serial clock must stay high and low for at least four system clock periods each.

Top module: `fram_spi_slave`

## Requirements
- R1: Opcode 0x06 (write-enable) sets the write-enable latch, and the latch survives the chip-select rise that ends the write-enable frame, so the next write frame stores its data.
- R2: A chip-select rise that ends any frame other than a write-enable frame clears the latch. A second write frame sent without a fresh write-enable stores nothing.
- R3: Opcode 0x04 (write-disable) clears the latch at once.
- R4: A write frame (opcode 0x02) that arrives while the latch is clear leaves every memory byte unchanged.
- R5: Only the first byte of a frame is decoded as an opcode. Bytes that follow a write-enable or write-disable opcode in the same frame are ignored, even when they look like a write command.
- R6: A write frame is the opcode, a 16-bit address sent high byte first, and any number of data bytes. The data bytes go to consecutive addresses, and the burst ends only when chip-select rises.
- R7: A read frame (opcode 0x03 plus a 16-bit address) streams consecutive memory bytes on serial-out, MSB first, in SPI mode 0. Input is sampled on the rising edge of SCK and output changes on the falling edge.
- R8: Address bits 15 to 11 are ignored, and a burst wraps from 0x7FF to 0x000.
- R9: An unknown opcode is ignored until chip-select rises. It writes nothing and serial-out stays low.
- R10: After reset, serial-out is low and its output enable is low. The output enable is high only while the synchronised chip-select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the SPI pins |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sck | input | 1 | Serial clock from the master (mode 0) |
| spi_mosi | input | 1 | Serial data in |
| spi_miso | output | 1 | Serial data out |
| spi_miso_oe | output | 1 | Drive enable for serial-out; high means driven |

## Verification
The hardest case to reach from the pins is a write-enable latch that is set in a frame which later carries bytes shaped like a complete write command. That case separates "one opcode per frame" from the latch rules. The stimulus builds it on purpose. It then checks through a read frame that the embedded write left memory untouched, and sends a later write to show that the latch survived. Wrap-around and the ignored upper address bits are reached with directed addresses near 0x7FF and addresses with high bits set. Seeded random bursts mix enabled and non-enabled writes across the array.

// File: rtl/fram_pkg.sv
// Shared opcodes and decoder states for the SPI ferroelectric memory slave.
// Assumes 8-bit opcodes and MSB-first transfer.
package fram_pkg;
    localparam logic [7:0] OP_WREN  = 8'h06;
    localparam logic [7:0] OP_WRDI  = 8'h04;
    localparam logic [7:0] OP_WRITE = 8'h02;
    localparam logic [7:0] OP_READ  = 8'h03;

    typedef enum logic [2:0] {
        ST_OPC   = 3'd0,
        ST_ADDR  = 3'd1,
        ST_WDATA = 3'd2,
        ST_RDATA = 3'd3,
        ST_SKIP  = 3'd4
    } fram_state_e;
endpackage

// File: rtl/fram_in_sync.sv
// Multi-stage synchroniser for a bundle of asynchronous input pins.
// Assumes each bit is sampled independently; RST_VAL sets the idle level.
module fram_in_sync #(
    parameter int          W       = 2,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] q
);
    for (genvar g = 0; g < W; g++) begin : g_bit
        logic [STAGES-1:0] pipe;
        // Shift one pin through its flop chain.
        always_ff @(posedge clk) begin
            if (!rst_n) pipe <= {STAGES{RST_VAL[g]}};
            else        pipe <= {pipe[STAGES-2:0], din[g]};
        end
        assign q[g] = pipe[STAGES-1];
    end
endmodule

// File: rtl/fram_store.sv
// Byte array with one write port and one registered read port.
// Assumes no reset of the contents; the read data follows rd_addr one cycle later.
module fram_store #(
    parameter int AW = 11,
    parameter int DW = 8,
    localparam int DEPTH = 1 << AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);
    logic [DW-1:0] mem [DEPTH];

    // Store one byte when a write strobe arrives.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    // Register the byte at the current read address.
    always_ff @(posedge clk) begin
        if (!rst_n) rd_data <= '0;
        else        rd_data <= mem[rd_addr];
    end
endmodule

// File: rtl/fram_ctrl.sv
// Frame decoder: assembles bytes from SCK rising edges, decodes one opcode per
// frame, holds the write-enable latch, steps the burst address and drives
// serial-out on SCK falling edges. Assumes edge strobes are one cycle wide and
// that AW lies between 9 and 16.
module fram_ctrl
    import fram_pkg::*;
#(
    parameter int AW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_act,
    input  logic          cs_rise,
    input  logic          sck_rise,
    input  logic          sck_fall,
    input  logic          mosi_s,
    input  logic [7:0]    rd_data,
    output logic [AW-1:0] addr,
    output logic [AW-1:0] wr_addr,
    output logic          wr_en,
    output logic [7:0]    wr_data,
    output logic          miso,
    output logic          wel,
    output logic          frame_wren,
    output logic          wrdi_hit,
    output fram_state_e   state
);
    logic [6:0] sh;
    logic [2:0] cnt;
    logic       addr_phase;
    logic       is_wr;
    logic [7:0] rx_byte;

    assign rx_byte = {sh, mosi_s};

    // Frame sequencing, latch handling and serial-out update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh <= '0; cnt <= '0; addr_phase <= 1'b0; is_wr <= 1'b0;
            addr <= '0; wr_addr <= '0; wr_en <= 1'b0; wr_data <= '0;
            miso <= 1'b0; wel <= 1'b0; frame_wren <= 1'b0; wrdi_hit <= 1'b0;
            state <= ST_OPC;
        end else begin
            wr_en    <= 1'b0;
            wrdi_hit <= 1'b0;
            if (!cs_act) begin
                state <= ST_OPC; cnt <= '0; addr_phase <= 1'b0; miso <= 1'b0;
                if (cs_rise && !frame_wren) wel <= 1'b0;
                frame_wren <= 1'b0;
            end else if (sck_rise) begin
                sh  <= rx_byte[6:0];
                cnt <= cnt + 3'd1;
                if (cnt == 3'd7) begin
                    unique case (state)
                        ST_OPC: begin
                            if (rx_byte == OP_WREN) begin
                                wel <= 1'b1; frame_wren <= 1'b1; state <= ST_SKIP;
                            end else if (rx_byte == OP_WRDI) begin
                                wel <= 1'b0; wrdi_hit <= 1'b1; state <= ST_SKIP;
                            end else if (rx_byte == OP_WRITE) begin
                                is_wr <= 1'b1; state <= ST_ADDR;
                            end else if (rx_byte == OP_READ) begin
                                is_wr <= 1'b0; state <= ST_ADDR;
                            end else begin
                                state <= ST_SKIP;
                            end
                        end
                        ST_ADDR: begin
                            if (!addr_phase) begin
                                addr[AW-1:8] <= rx_byte[AW-9:0];
                                addr_phase   <= 1'b1;
                            end else begin
                                addr[7:0] <= rx_byte;
                                state     <= is_wr ? ST_WDATA : ST_RDATA;
                            end
                        end
                        ST_WDATA: begin
                            if (wel) begin
                                wr_en <= 1'b1; wr_data <= rx_byte; wr_addr <= addr;
                            end
                            addr <= addr + 1'b1;
                        end
                        ST_RDATA: addr <= addr + 1'b1;
                        default: ;
                    endcase
                end
            end else if (sck_fall && state == ST_RDATA) begin
                miso <= rd_data[~cnt];
            end
        end
    end
endmodule

// File: rtl/fram_spi_slave.sv
// Top of the SPI ferroelectric memory slave. Synchronises the pins, derives
// SCK and chip-select edges and joins the decoder to the byte array.
// Assumes SCK high and low phases of at least four clk periods.
module fram_spi_slave
    import fram_pkg::*;
#(
    parameter int ADDR_W      = 11,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic spi_cs_n,
    input  logic spi_sck,
    input  logic spi_mosi,
    output logic spi_miso,
    output logic spi_miso_oe
);
    logic [2:0]        pins_s;
    logic              cs_s, sck_s, mosi_s;
    logic              cs_d, sck_d;
    logic              cs_act, cs_rise, sck_rise, sck_fall;
    logic [ADDR_W-1:0] addr, wr_addr;
    logic              wr_en, wel, frame_wren, wrdi_hit;
    logic [7:0]        wr_data, rd_data;
    fram_state_e       state;

    fram_in_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) i_sync (
        .clk(clk), .rst_n(rst_n),
        .din({spi_cs_n, spi_sck, spi_mosi}), .q(pins_s)
    );
    assign {cs_s, sck_s, mosi_s} = pins_s;

    // Remember the previous synchronised levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin cs_d <= 1'b1; sck_d <= 1'b0; end
        else        begin cs_d <= cs_s; sck_d <= sck_s; end
    end

    assign cs_act   = ~cs_s;
    assign cs_rise  = cs_s & ~cs_d;
    assign sck_rise = sck_s & ~sck_d & cs_act;
    assign sck_fall = ~sck_s & sck_d & cs_act;

    fram_ctrl #(.AW(ADDR_W)) i_ctrl (
        .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .cs_rise(cs_rise),
        .sck_rise(sck_rise), .sck_fall(sck_fall), .mosi_s(mosi_s),
        .rd_data(rd_data), .addr(addr), .wr_addr(wr_addr), .wr_en(wr_en),
        .wr_data(wr_data), .miso(spi_miso), .wel(wel),
        .frame_wren(frame_wren), .wrdi_hit(wrdi_hit), .state(state)
    );

    fram_store #(.AW(ADDR_W), .DW(8)) i_store (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(addr), .rd_data(rd_data)
    );

    assign spi_miso_oe = cs_act;
endmodule

// File: rtl/fram_spi_checker.sv
// Property checker for the SPI ferroelectric memory slave, bound to the top.
// Assumes it observes internal nets of the top by name.
module fram_spi_checker
    import fram_pkg::*;
#(
    parameter int AW = 11
) (
    input logic          clk,
    input logic          rst_n,
    input logic          spi_cs_n,
    input logic          spi_miso_oe,
    input logic          cs_act,
    input logic          cs_rise,
    input logic          wel,
    input logic          frame_wren,
    input logic          wrdi_hit,
    input logic          wr_en,
    input logic [AW-1:0] wr_addr,
    input logic [AW-1:0] addr,
    input fram_state_e   state
);
    assert_oe_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_cs_n && $past(spi_cs_n) && $past(spi_cs_n, 2) && $past(spi_cs_n, 3))
        |-> !spi_miso_oe);

    assert_write_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> ($past(wel) && cs_act));

    assert_wel_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wel) |-> ($past(cs_rise) || wrdi_hit));

    assert_wel_rise_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wel) |-> frame_wren);

    assert_addr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (addr == AW'(wr_addr + 1'b1)));

    assert_one_opcode_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_act && state != ST_OPC) |=> (state != ST_OPC || !cs_act));
endmodule

bind fram_spi_slave fram_spi_checker #(.AW(ADDR_W)) i_chk (
    .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_miso_oe(spi_miso_oe),
    .cs_act(cs_act), .cs_rise(cs_rise), .wel(wel), .frame_wren(frame_wren),
    .wrdi_hit(wrdi_hit), .wr_en(wr_en), .wr_addr(wr_addr), .addr(addr),
    .state(state)
);

// File: tb/test_fram_spi_slave.sv
// Self-checking bench: directed corner cases plus seeded random bursts, with
// the memory and latch predicted by a bench-side model.
module test_fram_spi_slave;
    localparam int HALF = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, sck = 1'b0, mosi = 1'b0;
    logic miso, miso_oe;

    int checks = 0, errors = 0;
    bit done = 0;
    logic [7:0] exp_mem [2048];
    bit         valid   [2048];
    bit         m_wel = 0;
    logic [7:0] wbuf [512];
    logic [7:0] rbuf [512];

    always #5 clk = ~clk;

    fram_spi_slave i_fram_spi_slave (
        .clk(clk), .rst_n(rst_n), .spi_cs_n(cs_n), .spi_sck(sck),
        .spi_mosi(mosi), .spi_miso(miso), .spi_miso_oe(miso_oe)
    );

    function automatic int wrap(input int a);
        return a & 16'h07FF;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic xbyte(input logic [7:0] tx, output logic [7:0] rx);
        for (int i = 7; i >= 0; i--) begin
            mosi = tx[i];
            repeat (HALF) @(negedge clk);
            rx[i] = miso;
            sck = 1'b1;
            repeat (HALF) @(negedge clk);
            sck = 1'b0;
        end
    endtask

    task automatic cs_low();
        cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        check(miso_oe === 1'b1, "R10 oe in frame", miso_oe, 1);
    endtask

    task automatic cs_high(input bit wren_frame);
        repeat (HALF) @(negedge clk);
        cs_n = 1'b1;
        if (!wren_frame) m_wel = 0;
        repeat (3 * HALF) @(negedge clk);
    endtask

    task automatic op_only(input logic [7:0] opc);
        logic [7:0] r;
        cs_low();
        xbyte(opc, r);
        if (opc == 8'h06) m_wel = 1;
        if (opc == 8'h04) m_wel = 0;
        cs_high(opc == 8'h06);
    endtask

    // Write frame: model stores bytes only while the latch is set (R4, R6, R8).
    task automatic wr_frame(input logic [15:0] a, input int n);
        logic [7:0] r;
        cs_low();
        xbyte(8'h02, r); xbyte(a[15:8], r); xbyte(a[7:0], r);
        for (int i = 0; i < n; i++) begin
            xbyte(wbuf[i], r);
            if (m_wel) begin
                exp_mem[wrap(int'(a) + i)] = wbuf[i];
                valid[wrap(int'(a) + i)] = 1;
            end
        end
        cs_high(0);
    endtask

    task automatic rd_frame(input logic [15:0] a, input int n);
        logic [7:0] r;
        cs_low();
        xbyte(8'h03, r); xbyte(a[15:8], r); xbyte(a[7:0], r);
        for (int i = 0; i < n; i++) begin
            xbyte(8'h00, r);
            rbuf[i] = r;
        end
        cs_high(0);
    endtask

    task automatic verify(input logic [15:0] a, input int n, input string req);
        rd_frame(a, n);
        for (int i = 0; i < n; i++) begin
            if (valid[wrap(int'(a) + i)])
                check(rbuf[i] === exp_mem[wrap(int'(a) + i)], req,
                      rbuf[i], exp_mem[wrap(int'(a) + i)]);
        end
    endtask

    task automatic fill(input int n);
        for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] r;
        void'($urandom(32'h5EED_0042));
        for (int i = 0; i < 2048; i++) valid[i] = 0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        // R10: reset state of serial-out and its enable.
        check(miso_oe === 1'b0, "R10 reset oe", miso_oe, 0);
        check(miso === 1'b0, "R10 reset miso", miso, 0);

        // R1, R6, R7: enable, burst write, read back.
        fill(16); op_only(8'h06); wr_frame(16'h0100, 16);
        verify(16'h0100, 16, "R7 readback");

        // R2, R4: latch cleared by the previous write frame's end.
        fill(16); wr_frame(16'h0100, 16);
        verify(16'h0100, 16, "R2 no rewrite");

        // R3: write-disable after write-enable.
        op_only(8'h06); op_only(8'h04);
        fill(8); wr_frame(16'h0104, 8);
        verify(16'h0100, 16, "R3 wrdi blocks");

        // R9: unknown opcode is ignored, serial-out stays low, latch is cleared.
        op_only(8'h06);
        cs_low(); xbyte(8'hA5, r); xbyte(8'h01, r); xbyte(8'h00, r);
        for (int i = 0; i < 3; i++) begin
            xbyte(8'hFF, r);
            check(r === 8'h00, "R9 miso quiet", r, 0);
        end
        cs_high(0);
        fill(4); wr_frame(16'h0100, 4);
        verify(16'h0100, 16, "R2 cleared by other frame");

        // R5: write command embedded in a write-enable frame stores nothing.
        cs_low(); xbyte(8'h06, r); xbyte(8'h02, r); xbyte(8'h01, r); xbyte(8'h00, r);
        xbyte(8'h5A, r); xbyte(8'h5A, r);
        m_wel = 1;
        cs_high(1);
        fill(1); wbuf[0] = 8'hC3; wr_frame(16'h0180, 1);
        check(valid[16'h180] && exp_mem[16'h180] == 8'hC3, "R1 model latch", 0, 0);
        verify(16'h0100, 16, "R5 embedded ignored");
        verify(16'h0180, 1, "R1 latch kept");

        // R8: wrap at the top and ignored high address bits.
        fill(4); op_only(8'h06); wr_frame(16'h07FE, 4);
        verify(16'h07FE, 4, "R8 wrap");
        verify(16'h0000, 2, "R8 wrap low");
        fill(2); op_only(8'h06); wr_frame(16'hF850, 2);
        verify(16'h0050, 2, "R8 high bits");

        // R6: long burst.
        fill(300); op_only(8'h06); wr_frame(16'h0200, 300);
        verify(16'h0200, 300, "R6 long burst");

        // Random bursts, with and without enable.
        for (int k = 0; k < 24; k++) begin
            int a, n;
            a = int'($urandom_range(0, 16'hFFFF));
            n = int'($urandom_range(1, 20));
            fill(n);
            if ($urandom_range(0, 3) != 0) op_only(8'h06);
            wr_frame(16'(a), n);
            verify(16'(a), n, "R6 random");
        end

        // R10: enable drops once chip-select is high.
        check(miso_oe === 1'b0, "R10 idle oe", miso_oe, 0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule